// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block moves one received frame at a time from a byte stream into memory buffers. The buffers are described by a ring of 8-byte descriptors. Before it accepts a payload byte, the block reads the descriptor at its current ring position. A descriptor may be used only when its empty flag is set. Payload bytes go into the buffer that the descriptor points to. When the payload ends, the four CRC bytes that arrive with the closing beat are stored directly after the payload. They may run past the end of one buffer and into the next one.

Each buffer that is used gets one descriptor write-back, carrying its byte count and its flags with the empty flag cleared. Only the descriptor that closes the frame receives the last flag and the frame's error status. There are two length checks. A hard cap of 2032 stored payload bytes discards the excess and sets both the truncation flag and the length-error flag. A programmable soft limit sets only the length-error flag. One pulse marks every intermediate buffer and another marks the buffer that closes the frame.

The ring may run out of empty descriptors while a frame still has bytes to store. In that case the block stores nothing more and pulses an overrun output. It keeps accepting stream beats until the frame's closing beat, so the source drains normally. The descriptor pointer stays on the stalled entry so that software can refill the ring.

Top module: `rx_ring_filler`

## Requirements
- R1: Every descriptor write-back clears flag bit 15 (empty) and keeps the other original flag bits, including bit 13 (wrap).
- R2: Payload bytes beyond 2032 are accepted but not stored. The closing descriptor of such a frame carries bit 0 (truncated) and bit 5 (length error).
- R3: A frame whose stored payload count exceeds `cfg_user_limit` but does not exceed 2032 carries bit 5 in its closing descriptor, without bit 0.
- R4: Bit 11 (last) and the status bits 0 and 5 are set only in the descriptor that closes the frame. Intermediate descriptors carry none of them.
- R5: `irq_rx_buf` pulses for one cycle with each intermediate write-back. `irq_rx_frame` pulses for one cycle with the closing write-back. Neither pulses at any other time.
- R6: The four bytes of `s_tcrc` (captured on the closing beat) are written least significant byte first, directly after the last stored payload byte. When a buffer fills part-way through them, the rest go to the next descriptor's buffer.
- R7: After a write-back, the next descriptor address is `cfg_ring_base` if the written descriptor has bit 13 set, and otherwise the current address plus 8.
- R8: If a fetched descriptor lacks bit 15 while bytes of the frame remain, the block writes no further bytes and no write-back for that frame, and it pulses `rx_overrun` once. The ring position stays on that descriptor.
- R9: After an overrun during the payload, `s_tready` stays high until the beat with `s_tlast` has been consumed.
- R10: A buffer is closed when it holds `BUF_BYTES` bytes or when the frame ends. Its write-back length equals the number of bytes written into it.
- R11: After reset, `s_tready`, all write strobes and all pulses are low. The first descriptor read uses `cfg_ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 of the ring |
| cfg_user_limit | input | 16 | Soft payload length limit |
| s_tdata | input | 8 | Stream payload byte |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Final payload beat of the frame |
| s_tcrc | input | 32 | Frame CRC, sampled with the final beat |
| s_tready | output | 1 | Stream beat accepted |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | 32 | Descriptor read address |
| desc_rd_flags | input | 16 | Descriptor flags, valid one cycle after the request |
| desc_rd_bufptr | input | 32 | Descriptor buffer address, valid one cycle after the request |
| desc_wb_en | output | 1 | Descriptor write-back strobe |
| desc_wb_addr | output | 32 | Descriptor write-back address |
| desc_wb_flags | output | 16 | Flags written back |
| desc_wb_len | output | 16 | Byte count written back |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | 32 | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte |
| irq_rx_buf | output | 1 | Intermediate buffer closed pulse |
| irq_rx_frame | output | 1 | Frame closed pulse |
| rx_overrun | output | 1 | Ring exhausted pulse |

## Verification
A wrong fill count shows on the buffer write address in the very next write, and on the length field at the following write-back. A status latch that is wrong, or that is cleared at the wrong time, leaves the closing descriptor's flags wrong only at the end of the frame. For that reason the frames are sized to end on either side of the 2032 cap and of the soft limit. A descriptor pointer that steps wrongly becomes visible only at the next write-back address, which is at most one buffer later. The bench keeps its own copy of the ring and matches every byte write and every write-back against it as they happen.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned FLAG_W     = 16;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned CRC_BYTES  = 4;

  // flag positions shared with software
  localparam int unsigned F_EMPTY  = 15;
  localparam int unsigned F_WRAP   = 13;
  localparam int unsigned F_LAST   = 11;
  localparam int unsigned F_LENERR = 5;
  localparam int unsigned F_TRUNC  = 0;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_FILL,
    ST_CRC,
    ST_WB,
    ST_DRAIN
  } fill_state_e;

  // flags written back when a buffer is closed
  function automatic flags_t close_flags(flags_t orig, logic final_buf,
                                         logic trunc, logic lenerr);
    flags_t f;
    f = orig;
    f[F_EMPTY] = 1'b0;
    if (final_buf) begin
      f[F_LAST] = 1'b1;
      if (trunc)  f[F_TRUNC]  = 1'b1;
      if (lenerr) f[F_LENERR] = 1'b1;
    end
    return f;
  endfunction

  // ring step after a write-back
  function automatic addr_t step_desc(addr_t cur, addr_t base, logic wrap);
    return wrap ? base : cur + addr_t'(DESC_BYTES);
  endfunction

  // CRC byte selection, least significant byte first
  function automatic logic [7:0] crc_byte(logic [31:0] crc, logic [1:0] idx);
    logic [31:0] sh;
    sh = crc >> {idx, 3'b000};
    return sh[7:0];
  endfunction
endpackage

// File: rtl/rdf_len_tracker.sv
module rdf_len_tracker #(
  parameter int unsigned MAX_FRAME = 2032,
  parameter int unsigned LIMIT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               beat,
  input  logic [LIMIT_W-1:0] limit,
  output logic               store_ok,
  output logic               trunc,
  output logic               lenerr
);
  localparam int unsigned CNT_W = $clog2(MAX_FRAME + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             trunc_q;

  assign store_ok = cnt_q < CNT_W'(MAX_FRAME);
  assign trunc    = trunc_q;
  assign lenerr   = trunc_q | (32'(cnt_q) > 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (beat) begin
      if (store_ok) cnt_q   <= cnt_q + CNT_W'(1);
      else          trunc_q <= 1'b1;
    end
  end

  AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_FRAME)); // R2
  AST_TRUNC_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_q |-> (cnt_q == CNT_W'(MAX_FRAME))); // R2
endmodule

// File: rtl/rdf_desc_ptr.sv
module rdf_desc_ptr
  import rdf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t base,
  input  logic  advance,
  input  logic  wrap,
  output addr_t cur
);
  addr_t cur_q;
  logic  valid_q;

  // before the first write-back the ring start is used directly
  assign cur = valid_q ? cur_q : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      valid_q <= 1'b0;
    end else if (advance) begin
      cur_q   <= step_desc(cur, base, wrap);
      valid_q <= 1'b1;
    end
  end

  AST_STEP_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap) |=> (cur == $past(cur) + addr_t'(DESC_BYTES))); // R7
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (cur == $past(base))); // R7
  AST_HOLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && valid_q) |=> $stable(cur)); // R8
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
  import rdf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned MAX_FRAME = 2032,
  parameter int unsigned LIMIT_W   = 16,
  parameter int unsigned LEN_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cfg_ring_base,
  input  logic [LIMIT_W-1:0] cfg_user_limit,
  input  logic [7:0]         s_tdata,
  input  logic               s_tvalid,
  input  logic               s_tlast,
  input  logic [31:0]        s_tcrc,
  output logic               s_tready,
  output logic               desc_rd_en,
  output logic [31:0]        desc_rd_addr,
  input  logic [15:0]        desc_rd_flags,
  input  logic [31:0]        desc_rd_bufptr,
  output logic               desc_wb_en,
  output logic [31:0]        desc_wb_addr,
  output logic [15:0]        desc_wb_flags,
  output logic [LEN_W-1:0]   desc_wb_len,
  output logic               buf_wr_en,
  output logic [31:0]        buf_wr_addr,
  output logic [7:0]         buf_wr_data,
  output logic               irq_rx_buf,
  output logic               irq_rx_frame,
  output logic               rx_overrun
);
  localparam int unsigned FILL_W = $clog2(BUF_BYTES + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(BUF_BYTES);
  localparam logic [1:0] CRC_LAST_IDX = 2'(CRC_BYTES - 1);

  fill_state_e       state_q;
  addr_t             bufptr_q;
  flags_t            orig_q;
  logic [FILL_W-1:0] fill_q;
  logic [31:0]       crc_q;
  logic [1:0]        crc_idx_q;
  logic              in_crc_q;
  logic              crc_done_q;

  // named internal events
  addr_t             cur_desc;
  logic              beat_take;
  logic              beat_store;
  logic              desc_ok;
  logic              desc_stall;
  logic              close_buf;
  logic              crc_last;
  logic              store_ok;
  logic              st_trunc;
  logic              st_lenerr;
  logic              frame_clr;
  logic [FILL_W-1:0] fill_inc;
  logic [FILL_W-1:0] fill_after_beat;

  assign beat_take       = (state_q == ST_FILL) && s_tvalid;
  assign beat_store      = beat_take && store_ok;
  assign desc_ok         = (state_q == ST_WAIT) &&  desc_rd_flags[F_EMPTY];
  assign desc_stall      = (state_q == ST_WAIT) && !desc_rd_flags[F_EMPTY];
  assign close_buf       = (state_q == ST_WB);
  assign crc_last        = (crc_idx_q == CRC_LAST_IDX);
  assign frame_clr       = (state_q == ST_IDLE);
  assign fill_inc        = fill_q + FILL_W'(1);
  assign fill_after_beat = beat_store ? fill_inc : fill_q;

  assign s_tready     = (state_q == ST_FILL) || (state_q == ST_DRAIN);
  assign desc_rd_en   = (state_q == ST_FETCH);
  assign desc_rd_addr = cur_desc;

  rdf_len_tracker #(
    .MAX_FRAME (MAX_FRAME),
    .LIMIT_W   (LIMIT_W)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frame_clr),
    .beat     (beat_take),
    .limit    (cfg_user_limit),
    .store_ok (store_ok),
    .trunc    (st_trunc),
    .lenerr   (st_lenerr)
  );

  rdf_desc_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (cfg_ring_base),
    .advance (close_buf),
    .wrap    (orig_q[F_WRAP]),
    .cur     (cur_desc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      bufptr_q      <= '0;
      orig_q        <= '0;
      fill_q        <= '0;
      crc_q         <= '0;
      crc_idx_q     <= '0;
      in_crc_q      <= 1'b0;
      crc_done_q    <= 1'b0;
      desc_wb_en    <= 1'b0;
      desc_wb_addr  <= '0;
      desc_wb_flags <= '0;
      desc_wb_len   <= '0;
      buf_wr_en     <= 1'b0;
      buf_wr_addr   <= '0;
      buf_wr_data   <= '0;
      irq_rx_buf    <= 1'b0;
      irq_rx_frame  <= 1'b0;
      rx_overrun    <= 1'b0;
    end else begin
      desc_wb_en   <= 1'b0;
      buf_wr_en    <= 1'b0;
      irq_rx_buf   <= 1'b0;
      irq_rx_frame <= 1'b0;
      rx_overrun   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          in_crc_q   <= 1'b0;
          crc_done_q <= 1'b0;
          crc_idx_q  <= '0;
          if (s_tvalid) state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (desc_ok) begin
            bufptr_q <= desc_rd_bufptr;
            orig_q   <= desc_rd_flags;
            fill_q   <= '0;
            state_q  <= in_crc_q ? ST_CRC : ST_FILL;
          end else begin
            rx_overrun <= 1'b1;
            state_q    <= in_crc_q ? ST_IDLE : ST_DRAIN;
          end
        end
        ST_FILL: begin
          if (beat_store) begin
            buf_wr_en   <= 1'b1;
            buf_wr_addr <= bufptr_q + addr_t'(fill_q);
            buf_wr_data <= s_tdata;
            fill_q      <= fill_inc;
          end
          if (beat_take) begin
            if (s_tlast) begin
              crc_q    <= s_tcrc;
              in_crc_q <= 1'b1;
              state_q  <= (fill_after_beat == FILL_FULL) ? ST_WB : ST_CRC;
            end else if (fill_after_beat == FILL_FULL) begin
              state_q <= ST_WB;
            end
          end
        end
        ST_CRC: begin
          buf_wr_en   <= 1'b1;
          buf_wr_addr <= bufptr_q + addr_t'(fill_q);
          buf_wr_data <= crc_byte(crc_q, crc_idx_q);
          fill_q      <= fill_inc;
          crc_idx_q   <= crc_idx_q + 2'd1;
          crc_done_q  <= crc_last;
          if (crc_last || (fill_inc == FILL_FULL)) state_q <= ST_WB;
        end
        ST_WB: begin
          desc_wb_en    <= 1'b1;
          desc_wb_addr  <= cur_desc;
          desc_wb_flags <= close_flags(orig_q, crc_done_q, st_trunc, st_lenerr);
          desc_wb_len   <= LEN_W'(fill_q);
          irq_rx_frame  <= crc_done_q;
          irq_rx_buf    <= !crc_done_q;
          state_q       <= crc_done_q ? ST_IDLE : ST_FETCH;
        end
        ST_DRAIN: begin
          if (s_tvalid && s_tlast) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WB_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb_en |-> !desc_wb_flags[F_EMPTY]); // R1
  AST_LAST_WITH_FRAME_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb_en |-> (desc_wb_flags[F_LAST] == irq_rx_frame)); // R4
  AST_STATUS_ONLY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wb_en && !irq_rx_frame) |-> (!desc_wb_flags[F_TRUNC] && !desc_wb_flags[F_LENERR]
                                       && !orig_q[F_TRUNC] || !desc_wb_en)); // R4
  AST_IRQ_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_buf || irq_rx_frame) |-> (desc_wb_en && !(irq_rx_buf && irq_rx_frame))); // R5
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_stall |=> (rx_overrun && !buf_wr_en && !desc_wb_en)); // R8
  AST_WR_WITHIN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ((fill_q != '0) && (fill_q <= FILL_FULL))); // R10
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DRAIN) && !(s_tvalid && s_tlast)) |=> s_tready); // R9
endmodule

// File: tb/rx_ring_filler_tb_top.sv
`timescale 1ns/1ps
module rx_ring_filler_tb_top;
  localparam int BUF   = 64;
  localparam int NDESC = 40;
  localparam int MAXF  = 2032;
  localparam logic [31:0] RING = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ring_base = RING;
  logic [15:0] cfg_user_limit = 16'd1500;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic [31:0] s_tcrc = '0;
  logic        s_tready;
  logic        desc_rd_en;
  logic [31:0] desc_rd_addr;
  logic [15:0] desc_rd_flags = '0;
  logic [31:0] desc_rd_bufptr = '0;
  logic        desc_wb_en;
  logic [31:0] desc_wb_addr;
  logic [15:0] desc_wb_flags;
  logic [15:0] desc_wb_len;
  logic        buf_wr_en;
  logic [31:0] buf_wr_addr;
  logic [7:0]  buf_wr_data;
  logic        irq_rx_buf;
  logic        irq_rx_frame;
  logic        rx_overrun;

  always #2 clk = ~clk;

  rx_ring_filler #(.BUF_BYTES(BUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
    .cfg_user_limit(cfg_user_limit), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tcrc(s_tcrc), .s_tready(s_tready),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
    .desc_rd_flags(desc_rd_flags), .desc_rd_bufptr(desc_rd_bufptr),
    .desc_wb_en(desc_wb_en), .desc_wb_addr(desc_wb_addr),
    .desc_wb_flags(desc_wb_flags), .desc_wb_len(desc_wb_len),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .irq_rx_buf(irq_rx_buf), .irq_rx_frame(irq_rx_frame), .rx_overrun(rx_overrun)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int ovr_seen = 0;
  int ovr_exp = 0;
  int model_cur = 0;
  string flag_req = "R4";

  logic [15:0] mem_flags [NDESC];
  logic [15:0] exp_flags [NDESC];

  logic [31:0] q_waddr[$];
  logic [7:0]  q_wdata[$];
  logic [31:0] q_baddr[$];
  logic [15:0] q_bflags[$];
  int          q_blen[$];
  bit          q_bfin[$];

  function automatic logic [31:0] bufptr_of(int i);
    return 32'h0010_0000 + 32'(i) * 32'h100;
  endfunction

  function automatic int idx_of(logic [31:0] a);
    int i;
    i = int'((a - RING) >> 3);
    if (i < 0 || i >= NDESC) i = 0;
    return i;
  endfunction

  function automatic logic [7:0] pbyte(int i, int seed);
    return 8'((i * 7 + seed * 13 + 5) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // descriptor memory: write-back first, then serve the read
  always @(posedge clk) begin
    if (desc_wb_en) mem_flags[idx_of(desc_wb_addr)] = desc_wb_flags;
    if (desc_rd_en) begin
      desc_rd_flags  <= mem_flags[idx_of(desc_rd_addr)];
      desc_rd_bufptr <= bufptr_of(idx_of(desc_rd_addr));
    end
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (buf_wr_en) begin
        if (q_waddr.size() == 0) begin
          check(0, "R8", "unexpected byte write", longint'(buf_wr_addr), 0);
        end else begin
          check(buf_wr_addr == q_waddr[0], "R10", "byte address", buf_wr_addr, q_waddr[0]);
          check(buf_wr_data == q_wdata[0], "R6", "byte value", buf_wr_data, q_wdata[0]);
          void'(q_waddr.pop_front());
          void'(q_wdata.pop_front());
        end
      end
      if (desc_wb_en) begin
        if (q_baddr.size() == 0) begin
          check(0, "R8", "unexpected write-back", longint'(desc_wb_addr), 0);
        end else begin
          check(desc_wb_addr == q_baddr[0], "R7", "write-back address", desc_wb_addr, q_baddr[0]);
          check(desc_wb_flags == q_bflags[0], (q_bfin[0] ? flag_req : "R1"), "write-back flags",
                desc_wb_flags, q_bflags[0]);
          check(int'(desc_wb_len) == q_blen[0], "R10", "write-back length", desc_wb_len, q_blen[0]);
          check(irq_rx_frame == q_bfin[0] && irq_rx_buf == !q_bfin[0], "R5", "irq pair",
                {irq_rx_frame, irq_rx_buf}, {q_bfin[0], !q_bfin[0]});
          void'(q_baddr.pop_front());
          void'(q_bflags.pop_front());
          void'(q_blen.pop_front());
          void'(q_bfin.pop_front());
        end
      end else if (irq_rx_buf || irq_rx_frame) begin
        check(0, "R5", "pulse without write-back", {irq_rx_frame, irq_rx_buf}, 0);
      end
      if (rx_overrun) ovr_seen++;
    end
    if (cycles > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic arm_ring(int wrap_idx, int empty_from, int empty_cnt);
    for (int i = 0; i < NDESC; i++) begin
      logic [15:0] f;
      f = 16'h0040;
      if (i >= empty_from && i < empty_from + empty_cnt) f[15] = 1'b1;
      if (i == wrap_idx) f[13] = 1'b1;
      mem_flags[i] = f;
      exp_flags[i] = f;
    end
  endtask

  // behavioural reference for one frame
  task automatic predict(int n, int limit, logic [31:0] crc, int seed);
    int size;
    int total;
    int pos;
    logic [15:0] st;
    size = (n > MAXF) ? MAXF : n;
    st = 16'h0000;
    if (n > MAXF) st = st | 16'h0021;
    if (size > limit) st = st | 16'h0020;
    total = size + 4;
    pos = 0;
    while (pos < total) begin
      int idx;
      int chunk;
      bit fin;
      logic [15:0] fl;
      idx = model_cur;
      if (!exp_flags[idx][15]) begin
        ovr_exp++;
        break;
      end
      chunk = (total - pos < BUF) ? total - pos : BUF;
      for (int k = 0; k < chunk; k++) begin
        int p;
        logic [31:0] sh;
        p = pos + k;
        sh = crc >> (8 * (p - size));
        q_waddr.push_back(bufptr_of(idx) + 32'(k));
        q_wdata.push_back(p < size ? pbyte(p, seed) : sh[7:0]);
      end
      fin = (pos + chunk == total);
      fl = exp_flags[idx] & 16'h7FFF;
      if (fin) fl = fl | st | 16'h0800;
      q_baddr.push_back(RING + 32'(idx) * 32'd8);
      q_bflags.push_back(fl);
      q_blen.push_back(chunk);
      q_bfin.push_back(fin);
      exp_flags[idx] = fl;
      model_cur = fl[13] ? 0 : idx + 1;
      pos += chunk;
    end
  endtask

  task automatic run_frame(int n, int limit, logic [31:0] crc, int seed, string req);
    int taken;
    int guard;
    flag_req = req;
    cfg_user_limit = 16'(limit);
    predict(n, limit, crc, seed);
    taken = 0;
    for (int i = 0; i < n; i++) begin
      int w;
      s_tvalid = 1'b1;
      s_tdata  = pbyte(i, seed);
      s_tlast  = (i == n - 1);
      s_tcrc   = crc;
      w = 0;
      while (!s_tready && w < 200) begin
        @(negedge clk);
        w++;
      end
      if (!s_tready) break;
      @(negedge clk);
      taken++;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    check(taken == n, "R9", "beats consumed", taken, n);
    guard = 0;
    while ((q_waddr.size() != 0 || q_baddr.size() != 0) && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    check(q_waddr.size() == 0, "R10", "pending byte writes", q_waddr.size(), 0);
    check(q_baddr.size() == 0, "R5", "pending write-backs", q_baddr.size(), 0);
    check(ovr_seen == ovr_exp, "R8", "overrun pulses", ovr_seen, ovr_exp);
    check(s_tready == 1'b0, "R9", "ready after frame", s_tready, 0);
  endtask

  initial begin
    arm_ring(NDESC - 1, 0, NDESC);
    repeat (3) @(negedge clk);
    // R11: reset state
    check(s_tready == 0 && buf_wr_en == 0 && desc_wb_en == 0, "R11", "outputs in reset",
          {s_tready, buf_wr_en, desc_wb_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(irq_rx_buf == 0 && irq_rx_frame == 0 && rx_overrun == 0 && desc_rd_en == 0,
          "R11", "pulses idle", {irq_rx_buf, irq_rx_frame, rx_overrun, desc_rd_en}, 0);
    // R11 and R4: first frame at ring base, one descriptor
    run_frame(10, 1500, 32'hA1B2C3D4, 1, "R4");
    // R5 and R10: two buffers
    run_frame(100, 1500, 32'h11223344, 2, "R4");
    // R6: CRC split 2 + 2 across a boundary
    run_frame(62, 1500, 32'hDEADBEEF, 3, "R6");
    // R6: payload ends on the boundary, CRC entirely in next buffer
    run_frame(64, 1500, 32'h0BADF00D, 4, "R6");
    // R3: soft limit only
    run_frame(80, 50, 32'h55AA55AA, 5, "R3");
    // R2: hard cap with truncation
    arm_ring(NDESC - 1, 0, NDESC);
    run_frame(2040, 1500, 32'hCAFEBABE, 6, "R2");
    // R2 boundary: exactly at the cap, no flags
    arm_ring(NDESC - 1, 0, NDESC);
    run_frame(2032, 4000, 32'h01020304, 7, "R2");
    // R7: wrap bit in the middle of the ring
    arm_ring((model_cur + 1 < NDESC) ? model_cur + 1 : NDESC - 1, 0, NDESC);
    run_frame(150, 1500, 32'h89ABCDEF, 8, "R7");
    // R8 and R9: ring exhausted during the payload
    arm_ring(NDESC - 1, model_cur, 1);
    run_frame(100, 1500, 32'h13579BDF, 9, "R8");
    // R8: no empty descriptor at all
    arm_ring(NDESC - 1, 0, 0);
    run_frame(20, 1500, 32'h2468ACE0, 10, "R8");
    // R8: ring exhausted during the CRC
    arm_ring(NDESC - 1, model_cur, 1);
    run_frame(63, 1500, 32'hFEDCBA98, 11, "R8");
    // R1 and R7: recovery on the held position
    arm_ring(NDESC - 1, 0, NDESC);
    run_frame(30, 1500, 32'h0F1E2D3C, 12, "R1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule